// File: doc/BRIEF.md
# Control and Status Register Unit

This block keeps the architectural control state of a processor core: the program counter, a one-bit instruction-set mode flag, a 32-bit status word, and a bank of 64 control registers of 64 bits each. Writing the program counter splits the written value: bit 0 goes to the mode flag and the stored counter keeps the rest with bit 0 cleared. The mode flag has no other write path.

Control register 0 has no storage of its own. It is a view of the status word, zero-extended to 64 bits on read and truncated to 32 bits on write. Six named status flags each have a single-bit write port and a single-bit read port. These ports are selected by a 3-bit flag code, so firmware-visible flags can change one at a time without a read-modify-write of the whole word. All reads are combinational. All writes take effect at the next rising clock edge.

Top module: `csrUnit`

## Requirements
- R1: While `rstN` is low and after it is released, `pcOut`, `modeOut` and `statusOut` are zero, and every control register index reads zero.
- R2: When `pcWrEn` is high, after the next rising edge `pcOut` equals `pcWrData` with bit 0 cleared and `modeOut` equals `pcWrData[0]`.
- R3: `modeOut` changes only on a cycle with `pcWrEn` high. Control register writes and flag writes leave it unchanged.
- R4: Reading a nonzero index on `crRdIdx` returns the value last written to that index.
- R5: Reading index 0 returns `{32'b0, status}`.
- R6: Writing index 0 loads `crWrData[31:0]` into the status word and discards the upper 32 bits. No other index changes.
- R7: Writing a nonzero index changes only that register. The status word is left as it was.
- R8: Flag codes map to status bits as follows: 0 to bit 1 (saturation), 1 to bit 8 (divide Q), 2 to bit 9 (divide M), 3 to bit 12 (FP precision), 4 to bit 13 (FP transfer size), 5 to bit 14 (FP bank). A flag write with `flagWrEn` high replaces only that bit with `flagWrBit`. Codes 6 and 7 write nothing.
- R9: `flagRdBit` shows the status bit that `flagRdSel` maps to under the R8 encoding. Codes 6 and 7 read 0.
- R10: When an index-0 write and a flag write happen in the same cycle, the flag's bit takes `flagWrBit` and every other bit takes `crWrData`.
- R11: `statusOut` always shows the current 32-bit status word.
- R12: Reads are combinational. A read in the same cycle as a write to the same place returns the old value, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pcWrEn | input | 1 | Program counter write strobe |
| pcWrData | input | 64 | Value written to the program counter (bit 0 goes to the mode flag) |
| pcOut | output | 64 | Current program counter |
| modeOut | output | 1 | Current instruction-set mode flag |
| crRdIdx | input | 6 | Control register read index |
| crRdData | output | 64 | Control register read data (combinational) |
| crWrEn | input | 1 | Control register write strobe |
| crWrIdx | input | 6 | Control register write index |
| crWrData | input | 64 | Control register write data |
| flagWrEn | input | 1 | Single-flag write strobe |
| flagWrSel | input | 3 | Flag code to write |
| flagWrBit | input | 1 | New flag value |
| flagRdSel | input | 3 | Flag code to read |
| flagRdBit | output | 1 | Selected flag value |
| statusOut | output | 32 | Current status word |

## Verification
The bench first writes distinct patterns into every nonzero index and reads them all back. This separates real per-index storage from aliasing or decode faults. It then writes index 0 with data whose upper half is nonzero, which shows whether the status alias truncates correctly and whether it leaves slot storage alone. Each flag code is set and cleared against a background status word that is alternately all-zeros and all-ones. This exposes wrong bit positions and any disturbance of neighbouring bits. The unused codes, same-cycle collisions, and a long random mix of all ports then test priority and read-before-write timing against the reference model on every clock.

// File: rtl/csrUnitPkg.sv
package csrUnitPkg;
  localparam int SR_W      = 32;
  localparam int SR_POS_W  = $clog2(SR_W);
  localparam int FLAG_SEL_W = 3;

  typedef struct packed {
    logic                pcWr;
    logic                srWr;
    logic                slotWr;
    logic                flagWr;
    logic [SR_POS_W-1:0] flagWrPos;
    logic                flagRdOk;
    logic [SR_POS_W-1:0] flagRdPos;
  } csrStrobes_t;

  // Returns {valid, bit position} for a flag code.
  function automatic logic [SR_POS_W:0] flagMap(input logic [FLAG_SEL_W-1:0] code);
    logic [SR_POS_W:0] r;
    case (code)
      3'd0:    r = {1'b1, 5'd1};
      3'd1:    r = {1'b1, 5'd8};
      3'd2:    r = {1'b1, 5'd9};
      3'd3:    r = {1'b1, 5'd12};
      3'd4:    r = {1'b1, 5'd13};
      3'd5:    r = {1'b1, 5'd14};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/csrCtl.sv
module csrCtl
  import csrUnitPkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                  pcWrEn,
  input  logic                  crWrEn,
  input  logic [IDX_W-1:0]      crWrIdx,
  input  logic                  flagWrEn,
  input  logic [FLAG_SEL_W-1:0] flagWrSel,
  input  logic [FLAG_SEL_W-1:0] flagRdSel,
  output csrStrobes_t           stb
);
  logic [SR_POS_W:0] wrMap;
  logic [SR_POS_W:0] rdMap;
  logic              idxIsZero;

  always_comb begin
    wrMap     = flagMap(flagWrSel);
    rdMap     = flagMap(flagRdSel);
    idxIsZero = (crWrIdx == '0);

    stb.pcWr      = pcWrEn;
    stb.srWr      = crWrEn && idxIsZero;
    stb.slotWr    = crWrEn && !idxIsZero;
    stb.flagWr    = flagWrEn && wrMap[SR_POS_W];
    stb.flagWrPos = wrMap[SR_POS_W-1:0];
    stb.flagRdOk  = rdMap[SR_POS_W];
    stb.flagRdPos = rdMap[SR_POS_W-1:0];
  end
endmodule

// File: rtl/csrDp.sv
module csrDp
  import csrUnitPkg::*;
#(
  parameter int XLEN     = 64,
  parameter int CR_COUNT = 64,
  parameter int IDX_W    = $clog2(CR_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobes_t      stb,
  input  logic [XLEN-1:0]  pcWrData,
  input  logic [IDX_W-1:0] crWrIdx,
  input  logic [XLEN-1:0]  crWrData,
  input  logic [IDX_W-1:0] crRdIdx,
  input  logic             flagWrBit,
  output logic [XLEN-1:0]  pcOut,
  output logic             modeOut,
  output logic [XLEN-1:0]  crRdData,
  output logic [SR_W-1:0]  statusOut,
  output logic             flagRdBit
);
  logic [XLEN-1:0] pcQ;
  logic            modeQ;
  logic [SR_W-1:0] srQ;
  logic [SR_W-1:0] srNext;
  logic [XLEN-1:0] slotQ [1:CR_COUNT-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ   <= '0;
      modeQ <= 1'b0;
    end else if (stb.pcWr) begin
      pcQ   <= {pcWrData[XLEN-1:1], 1'b0};
      modeQ <= pcWrData[0];
    end
  end

  // Single-flag write overrides the full-word load for its own bit.
  always_comb begin
    srNext = srQ;
    if (stb.srWr)   srNext = crWrData[SR_W-1:0];
    if (stb.flagWr) srNext[stb.flagWrPos] = flagWrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srQ <= '0;
    else       srQ <= srNext;
  end

  for (genvar gi = 1; gi < CR_COUNT; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[gi] <= '0;
      else if (stb.slotWr && (crWrIdx == IDX_W'(gi)))
        slotQ[gi] <= crWrData;
    end
  end

  always_comb begin
    if (crRdIdx == '0) crRdData = {{(XLEN-SR_W){1'b0}}, srQ};
    else               crRdData = slotQ[crRdIdx];
  end

  assign pcOut     = pcQ;
  assign modeOut   = modeQ;
  assign statusOut = srQ;
  assign flagRdBit = stb.flagRdOk ? srQ[stb.flagRdPos] : 1'b0;

  // R2
  pc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcWr |=> (pcOut == {$past(pcWrData[XLEN-1:1]), 1'b0}) && (modeOut == $past(pcWrData[0])));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pcWr |=> $stable(modeOut));

  // R6
  sr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.srWr && !stb.flagWr) |=> statusOut == $past(crWrData[SR_W-1:0]));

  // R7
  slot_keeps_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.slotWr && !stb.flagWr) |=> $stable(statusOut));

  // R8
  flag_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagWr && !stb.srWr) |=>
      (((statusOut ^ $past(statusOut)) & ~(SR_W'(1) << $past(stb.flagWrPos))) == '0)
      && (statusOut[$past(stb.flagWrPos)] == $past(flagWrBit)));
endmodule

// File: rtl/csrUnit.sv
module csrUnit
  import csrUnitPkg::*;
#(
  parameter int XLEN     = 64,
  parameter int CR_COUNT = 64,
  localparam int IDX_W   = $clog2(CR_COUNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pcWrEn,
  input  logic [XLEN-1:0]       pcWrData,
  output logic [XLEN-1:0]       pcOut,
  output logic                  modeOut,
  input  logic [IDX_W-1:0]      crRdIdx,
  output logic [XLEN-1:0]       crRdData,
  input  logic                  crWrEn,
  input  logic [IDX_W-1:0]      crWrIdx,
  input  logic [XLEN-1:0]       crWrData,
  input  logic                  flagWrEn,
  input  logic [FLAG_SEL_W-1:0] flagWrSel,
  input  logic                  flagWrBit,
  input  logic [FLAG_SEL_W-1:0] flagRdSel,
  output logic                  flagRdBit,
  output logic [SR_W-1:0]       statusOut
);
  csrStrobes_t stb;

  csrCtl #(.IDX_W(IDX_W)) u_ctl (
    .pcWrEn   (pcWrEn),
    .crWrEn   (crWrEn),
    .crWrIdx  (crWrIdx),
    .flagWrEn (flagWrEn),
    .flagWrSel(flagWrSel),
    .flagRdSel(flagRdSel),
    .stb      (stb)
  );

  csrDp #(.XLEN(XLEN), .CR_COUNT(CR_COUNT), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pcWrData (pcWrData),
    .crWrIdx  (crWrIdx),
    .crWrData (crWrData),
    .crRdIdx  (crRdIdx),
    .flagWrBit(flagWrBit),
    .pcOut    (pcOut),
    .modeOut  (modeOut),
    .crRdData (crRdData),
    .statusOut(statusOut),
    .flagRdBit(flagRdBit)
  );
endmodule

// File: tb/csrUnit_tb.sv
`timescale 1ns/1ps
module csrUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcWrEn = 1'b0;
  logic [63:0] pcWrData = '0;
  logic [63:0] pcOut;
  logic        modeOut;
  logic [5:0]  crRdIdx = '0;
  logic [63:0] crRdData;
  logic        crWrEn = 1'b0;
  logic [5:0]  crWrIdx = '0;
  logic [63:0] crWrData = '0;
  logic        flagWrEn = 1'b0;
  logic [2:0]  flagWrSel = '0;
  logic        flagWrBit = 1'b0;
  logic [2:0]  flagRdSel = '0;
  logic        flagRdBit;
  logic [31:0] statusOut;

  int vectors = 0;
  int fails = 0;

  // reference state
  logic [63:0] mPc = '0;
  logic        mMode = 1'b0;
  logic [31:0] mSr = '0;
  logic [63:0] mCr [64];

  always #2.5 clk = ~clk;

  csrUnit u_dut (
    .clk(clk), .rstN(rstN), .pcWrEn(pcWrEn), .pcWrData(pcWrData),
    .pcOut(pcOut), .modeOut(modeOut), .crRdIdx(crRdIdx), .crRdData(crRdData),
    .crWrEn(crWrEn), .crWrIdx(crWrIdx), .crWrData(crWrData),
    .flagWrEn(flagWrEn), .flagWrSel(flagWrSel), .flagWrBit(flagWrBit),
    .flagRdSel(flagRdSel), .flagRdBit(flagRdBit), .statusOut(statusOut)
  );

  // R8 encoding: code -> status bit, -1 for unused codes
  function automatic int flagBitOf(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 8;
      3'd2: return 9;
      3'd3: return 12;
      3'd4: return 13;
      3'd5: return 14;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [63:0] expRd;
    logic        expFlag;
    int          fp;
    expRd = (crRdIdx == 0) ? {32'b0, mSr} : mCr[crRdIdx];
    fp = flagBitOf(flagRdSel);
    expFlag = (fp < 0) ? 1'b0 : mSr[fp];
    chk(tag, "pcOut(R2)", pcOut, mPc);
    chk(tag, "modeOut(R3)", {63'b0, modeOut}, {63'b0, mMode});
    chk(tag, "crRdData(R4/R5)", crRdData, expRd);
    chk(tag, "flagRdBit(R9)", {63'b0, flagRdBit}, {63'b0, expFlag});
    chk(tag, "statusOut(R11)", {32'b0, statusOut}, {32'b0, mSr});
  endtask

  task automatic modelStep();
    int fp;
    if (pcWrEn) begin
      mPc   = {pcWrData[63:1], 1'b0};
      mMode = pcWrData[0];
    end
    if (crWrEn) begin
      if (crWrIdx == 0) mSr = crWrData[31:0];
      else              mCr[crWrIdx] = crWrData;
    end
    fp = flagBitOf(flagWrSel);
    if (flagWrEn && fp >= 0) mSr[fp] = flagWrBit;
  endtask

  // inputs are set at a falling edge; compare, then let the edge apply them
  task automatic tick(input string tag);
    #1;
    compareAll(tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    pcWrEn = 0; crWrEn = 0; flagWrEn = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mCr[i] = '0;
    // R1: during reset
    @(negedge clk);
    #1;
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    // R1: every index reads zero after release
    for (int i = 0; i < 64; i++) begin
      crRdIdx = 6'(i);
      tick("R1");
    end

    // R2: pc writes with odd, even and all-ones data
    pcWrEn = 1;
    pcWrData = 64'h0123_4567_89AB_CDEF; tick("R2");
    pcWrData = 64'hFEDC_BA98_7654_3210; tick("R2");
    pcWrData = '1;                      tick("R2");
    idle();
    tick("R2");

    // R3: other writes leave the mode flag alone
    crWrEn = 1; crWrIdx = 6'd5; crWrData = 64'h0; tick("R3");
    crWrIdx = 6'd0; tick("R3");
    idle(); flagWrEn = 1; flagWrSel = 3'd2; flagWrBit = 1; tick("R3");
    idle(); tick("R3");

    // R4/R7: fill every nonzero slot with a distinct pattern, reading the same slot (R12)
    crWrEn = 1;
    for (int i = 1; i < 64; i++) begin
      crWrIdx = 6'(i);
      crRdIdx = 6'(i);
      crWrData = {32'(i) * 32'h0101_0101, ~(32'(i) * 32'h1357_9BDF)};
      tick("R12");
    end
    idle();
    for (int i = 0; i < 64; i++) begin
      crRdIdx = 6'(i);
      tick("R4");
    end

    // R5/R6: status alias load discards upper half and touches no slot
    crWrEn = 1; crWrIdx = 0; crWrData = 64'hDEAD_BEEF_1234_5678; crRdIdx = 0;
    tick("R6");
    idle();
    tick("R5");
    crRdIdx = 6'd1;  tick("R6");
    crRdIdx = 6'd63; tick("R6");

    // R8/R9: each code set and cleared against zero and ones backgrounds
    for (int bg = 0; bg < 2; bg++) begin
      crWrEn = 1; crWrIdx = 0; crWrData = bg ? '1 : '0; tick("R8");
      idle();
      for (int c = 0; c < 8; c++) begin
        flagWrEn = 1; flagWrSel = 3'(c); flagRdSel = 3'(c); flagWrBit = ~bg[0];
        tick("R8");
        flagWrEn = 0; crRdIdx = 0;
        tick("R9");
        flagWrEn = 1; flagWrBit = bg[0];
        tick("R8");
        flagWrEn = 0;
        tick("R9");
      end
    end

    // R10: simultaneous full-word load and flag write
    for (int c = 0; c < 6; c++) begin
      crWrEn = 1; crWrIdx = 0; crWrData = 64'h0000_0000_A5A5_5A5A;
      flagWrEn = 1; flagWrSel = 3'(c); flagWrBit = 1'b1; flagRdSel = 3'(c);
      tick("R10");
      crWrData = 64'hFFFF_FFFF_FFFF_FFFF; flagWrBit = 1'b0;
      tick("R10");
    end
    idle();
    tick("R10");

    // R12: random mix on all ports
    for (int n = 0; n < 2000; n++) begin
      pcWrEn    = ($urandom_range(0, 3) == 0);
      pcWrData  = {$urandom, $urandom};
      crWrEn    = $urandom_range(0, 1) == 1;
      crWrIdx   = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom);
      crWrData  = {$urandom, $urandom};
      crRdIdx   = ($urandom_range(0, 1) == 1) ? crWrIdx : 6'($urandom);
      flagWrEn  = $urandom_range(0, 1) == 1;
      flagWrSel = 3'($urandom);
      flagWrBit = 1'($urandom);
      flagRdSel = 3'($urandom);
      tick("R12");
    end
    idle();
    tick("R12");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule